// File: doc/BRIEF.md
# Scan-Path State Machine with Test Sequencer

A small sequential circuit whose three state flip-flops are built as two-port cells. Each cell either captures the next state from the combinational core (the system step) or takes a serial bit from its neighbour (the test shift). In test shifting, the cells form one chain: serial input enters Q1, Q1 feeds Q2, Q2 feeds Q3, and Q3 drives the single serial output. The core reads two inputs X1X2 and the present state Q1Q2Q3, and produces the next state and two outputs Z1Z2.

The whole block runs on one clock. The two clocks of a classic scan-path circuit become two enables: a capture step and a shift step. When the sequencer is idle, the two-port cells are driven from external pins. A sequencer can also run one test vector by itself. It shifts the vector's state in, applies X, lets Z settle and samples it, then issues one capture step. The state captured by one vector is shifted out while the next vector is shifted in, so each result comes back during the following run. A flush run shifts in zeros only and returns the last captured state.

Top module: `scan_path_top`

## Requirements
- R1: While rst is high and on the first cycle after it, the state is 000, `z_out` is 00, `sdo` is 0, and `busy`, `res_valid` and `scan_valid` are 0.
- R2: A shift step moves sdi into Q1, Q1 into Q2 and Q2 into Q3. `sdo` always shows Q3. To load Q1Q2Q3, the bits are shifted in in the order Q3, Q2, Q1. On unload they appear on `sdo` in the order Q3, Q2, Q1.
- R3: A capture step without a shift loads the next state of the table. With neither step asserted, the state holds.
- R4: When shift and capture are asserted together, the shift wins.
- R5: `z_out` is registered. It shows Z1Z2 for the state and X (X1 = bit 1) present one clock earlier.
- R6: For present state 101, X1X2 = 00, 01, 11, 10 gives next state 010, 110, 011, 111 and Z1Z2 = 10, 11, 00, 01.
- R7: For every other state, the next state is {Q2^X1, Q3^X2, Q1^X1^X2} and Z1Z2 = {Q1^X2, Q2|X1}.
- R8: A start while idle makes the block busy for exactly 5 cycles. During that time it shifts `vec_st` in over 3 cycles, waits one settle cycle, and then samples Z and captures in one cycle. It then pulses `res_valid` with `res_z` = Z(vec_st, vec_x).
- R9: The shift of any run pulses `scan_valid` once, with `scan_st` = the state captured by the previous non-flush run, but only if such a run happened. A flush run is busy for 3 cycles and leaves the state at 000.
- R10: While busy, `start` and the external shift, capture, sdi and x pins have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_shift | input | 1 | External shift step (used while idle) |
| ext_cap | input | 1 | External capture step (used while idle) |
| ext_sdi | input | 1 | External serial data into Q1 |
| ext_x | input | 2 | External X1X2 (used while idle) |
| sdo | output | 1 | Serial output, equal to Q3 |
| z_out | output | 2 | Registered Z1Z2 |
| start | input | 1 | Begin a sequencer run |
| flush | input | 1 | Run only shifts zeros in and returns the pending result |
| vec_st | input | 3 | State vector Q1Q2Q3 to load |
| vec_x | input | 2 | X1X2 to apply for the vector |
| busy | output | 1 | Sequencer run in progress |
| res_valid | output | 1 | One-cycle pulse: res_z is valid |
| res_z | output | 2 | Z1Z2 sampled for the current vector |
| scan_valid | output | 1 | One-cycle pulse: scan_st is valid |
| scan_st | output | 3 | State captured by the previous run, shifted out |

## Verification
The bench checks the shift order from both ends. A chain wired in reverse would load the vector mirrored and return Q1 first. It checks the row for state 101 against all four inputs, where a table with a transposed entry would show up. It also presses shift and capture together, where the wrong priority would overwrite the shifted bit with the next state. Random vectors run back to back, and each `scan_st` is compared with the previous vector's next state. This catches a sequencer that samples `sdo` after the shift edge instead of before it, and one that loses the pending result. A start pulse and pin activity injected while busy check that a run cannot be disturbed halfway.

// File: rtl/sp_pkg.sv
package sp_pkg;
  localparam int ST_W = 3;
  localparam int X_W  = 2;
  localparam int Z_W  = 2;

  typedef enum logic [1:0] {
    CS_IDLE,
    CS_SHIFT,
    CS_SETTLE,
    CS_SAMPLE
  } ctl_state_t;

  // state bit 2 = Q1, bit 1 = Q2, bit 0 = Q3; x bit 1 = X1
  function automatic logic [ST_W-1:0] next_of(input logic [ST_W-1:0] q,
                                                input logic [X_W-1:0] x);
    logic [ST_W-1:0] r;
    if (q == 3'b101) begin
      case (x)
        2'b00:   r = 3'b010;
        2'b01:   r = 3'b110;
        2'b11:   r = 3'b011;
        default: r = 3'b111;
      endcase
    end else begin
      r = {q[1] ^ x[1], q[0] ^ x[0], q[2] ^ x[1] ^ x[0]};
    end
    return r;
  endfunction

  function automatic logic [Z_W-1:0] out_of(input logic [ST_W-1:0] q,
                                             input logic [X_W-1:0] x);
    logic [Z_W-1:0] r;
    if (q == 3'b101) begin
      case (x)
        2'b00:   r = 2'b10;
        2'b01:   r = 2'b11;
        2'b11:   r = 2'b00;
        default: r = 2'b01;
      endcase
    end else begin
      r = {q[2] ^ x[0], q[1] | x[1]};
    end
    return r;
  endfunction
endpackage

// File: rtl/sp_cell.sv
module sp_cell (
  input  logic clk,
  input  logic rst,
  input  logic shift_en,
  input  logic cap_en,
  input  logic si,
  input  logic d,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst)           q <= 1'b0;
    else if (shift_en) q <= si;
    else if (cap_en)   q <= d;
  end
endmodule

// File: rtl/sp_core.sv
module sp_core
  import sp_pkg::*;
#(
  parameter int SW = ST_W,
  parameter int XW = X_W,
  parameter int ZW = Z_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          shift_en,
  input  logic          cap_en,
  input  logic          sdi,
  input  logic [XW-1:0] x,
  output logic          sdo,
  output logic [ZW-1:0] z,
  output logic [SW-1:0] st
);
  logic [SW-1:0] nxt;
  logic [SW-1:0] ser_in;
  logic [ZW-1:0] z_q;

  assign nxt = next_of(st, x);

  genvar i;
  generate
    for (i = 0; i < SW; i++) begin : g_cell
      if (i == SW - 1) begin : g_head
        assign ser_in[i] = sdi;
      end else begin : g_link
        assign ser_in[i] = st[i+1];
      end
      sp_cell u_cell (
        .clk      (clk),
        .rst      (rst),
        .shift_en (shift_en),
        .cap_en   (cap_en),
        .si       (ser_in[i]),
        .d        (nxt[i]),
        .q        (st[i])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) z_q <= '0;
    else     z_q <= out_of(st, x);
  end

  assign z   = z_q;
  assign sdo = st[0];
endmodule

// File: rtl/sp_ctrl.sv
module sp_ctrl
  import sp_pkg::*;
#(
  parameter int SW = ST_W,
  parameter int XW = X_W,
  parameter int ZW = Z_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          flush,
  input  logic [SW-1:0] vec_st,
  input  logic [XW-1:0] vec_x,
  input  logic          sdo,
  input  logic [ZW-1:0] z_in,
  output logic          shift_en,
  output logic          cap_en,
  output logic          sdi,
  output logic [XW-1:0] x_out,
  output logic          busy,
  output logic          res_valid,
  output logic [ZW-1:0] res_z,
  output logic          scan_valid,
  output logic [SW-1:0] scan_st
);
  localparam int CW = (SW > 1) ? $clog2(SW) : 1;
  localparam logic [CW-1:0] LAST = CW'(SW - 1);

  ctl_state_t    cs;
  logic [CW-1:0] cnt;
  logic [SW-1:0] lat_st;
  logic [XW-1:0] lat_x;
  logic          lat_fl;
  logic          pend;
  logic [SW-1:0] grab;
  logic [SW-1:0] grab_nx;

  always_comb begin
    grab_nx      = grab;
    grab_nx[cnt] = sdo;
  end

  assign shift_en = (cs == CS_SHIFT);
  assign cap_en   = (cs == CS_SAMPLE);
  assign sdi      = lat_fl ? 1'b0 : lat_st[cnt];
  assign x_out    = lat_x;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs         <= CS_IDLE;
      cnt        <= '0;
      lat_st     <= '0;
      lat_x      <= '0;
      lat_fl     <= 1'b0;
      pend       <= 1'b0;
      grab       <= '0;
      busy       <= 1'b0;
      res_valid  <= 1'b0;
      res_z      <= '0;
      scan_valid <= 1'b0;
      scan_st    <= '0;
    end else begin
      res_valid  <= 1'b0;
      scan_valid <= 1'b0;
      case (cs)
        CS_IDLE: begin
          if (start) begin
            lat_st <= vec_st;
            lat_x  <= vec_x;
            lat_fl <= flush;
            cnt    <= '0;
            busy   <= 1'b1;
            cs     <= CS_SHIFT;
          end
        end
        CS_SHIFT: begin
          grab <= grab_nx;
          cnt  <= cnt + 1'b1;
          if (cnt == LAST) begin
            if (pend) begin
              scan_valid <= 1'b1;
              scan_st    <= grab_nx;
            end
            pend <= 1'b0;
            if (lat_fl) begin
              busy <= 1'b0;
              cs   <= CS_IDLE;
            end else begin
              cs <= CS_SETTLE;
            end
          end
        end
        CS_SETTLE: cs <= CS_SAMPLE;
        default: begin
          res_z     <= z_in;
          res_valid <= 1'b1;
          pend      <= 1'b1;
          busy      <= 1'b0;
          cs        <= CS_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/scan_path_top.sv
module scan_path_top
  import sp_pkg::*;
#(
  parameter int SW = ST_W,
  parameter int XW = X_W,
  parameter int ZW = Z_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ext_shift,
  input  logic          ext_cap,
  input  logic          ext_sdi,
  input  logic [XW-1:0] ext_x,
  output logic          sdo,
  output logic [ZW-1:0] z_out,
  input  logic          start,
  input  logic          flush,
  input  logic [SW-1:0] vec_st,
  input  logic [XW-1:0] vec_x,
  output logic          busy,
  output logic          res_valid,
  output logic [ZW-1:0] res_z,
  output logic          scan_valid,
  output logic [SW-1:0] scan_st
);
  logic          c_shift, c_cap, c_sdi;
  logic [XW-1:0] c_x;
  logic          core_shift, core_cap, core_sdi;
  logic [XW-1:0] core_x;
  logic [SW-1:0] core_st;

  assign core_shift = busy ? c_shift : ext_shift;
  assign core_cap   = busy ? c_cap   : ext_cap;
  assign core_sdi   = busy ? c_sdi   : ext_sdi;
  assign core_x     = busy ? c_x     : ext_x;

  sp_core #(.SW(SW), .XW(XW), .ZW(ZW)) u_core (
    .clk      (clk),
    .rst      (rst),
    .shift_en (core_shift),
    .cap_en   (core_cap),
    .sdi      (core_sdi),
    .x        (core_x),
    .sdo      (sdo),
    .z        (z_out),
    .st       (core_st)
  );

  sp_ctrl #(.SW(SW), .XW(XW), .ZW(ZW)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .flush      (flush),
    .vec_st     (vec_st),
    .vec_x      (vec_x),
    .sdo        (sdo),
    .z_in       (z_out),
    .shift_en   (c_shift),
    .cap_en     (c_cap),
    .sdi        (c_sdi),
    .x_out      (c_x),
    .busy       (busy),
    .res_valid  (res_valid),
    .res_z      (res_z),
    .scan_valid (scan_valid),
    .scan_st    (scan_st)
  );
endmodule

// File: rtl/sp_top_chk.sv
module sp_top_chk #(
  parameter int SW = 3,
  parameter int XW = 2,
  parameter int ZW = 2
) (
  input logic          clk,
  input logic          rst,
  input logic          core_shift,
  input logic          core_cap,
  input logic          core_sdi,
  input logic [SW-1:0] st,
  input logic [XW-1:0] core_x,
  input logic [ZW-1:0] z_out,
  input logic          sdo,
  input logic          busy,
  input logic          start,
  input logic          res_valid,
  input logic          scan_valid
);
  AST_SHIFT_CHAIN: assert property (@(posedge clk) disable iff (rst)
    core_shift |=> (st[SW-2:0] == $past(st[SW-1:1]))); // R2
  AST_SDO_IS_TAIL: assert property (@(posedge clk) disable iff (rst)
    core_shift |=> (sdo == $past(st[1]))); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!core_shift && !core_cap) |=> $stable(st)); // R3
  AST_SHIFT_WINS: assert property (@(posedge clk) disable iff (rst)
    (core_shift && core_cap) |=> (st[SW-1] == $past(core_sdi))); // R4
  AST_Z_STEADY: assert property (@(posedge clk) disable iff (rst)
    ($stable(st) && $stable(core_x)) |=> $stable(z_out)); // R5
  AST_START_ENTERS: assert property (@(posedge clk) disable iff (rst)
    (!busy && start) |=> busy); // R8
  AST_RES_ENDS_RUN: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> !busy); // R8
  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (rst)
    $onehot0({res_valid, scan_valid})); // R9
endmodule

bind scan_path_top sp_top_chk #(.SW(SW), .XW(XW), .ZW(ZW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .core_shift (core_shift),
  .core_cap   (core_cap),
  .core_sdi   (core_sdi),
  .st         (core_st),
  .core_x     (core_x),
  .z_out      (z_out),
  .sdo        (sdo),
  .busy       (busy),
  .start      (start),
  .res_valid  (res_valid),
  .scan_valid (scan_valid)
);

// File: tb/scan_path_top_bench.sv
module scan_path_top_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ext_shift = 1'b0, ext_cap = 1'b0, ext_sdi = 1'b0;
  logic [1:0] ext_x = 2'b00;
  logic       sdo;
  logic [1:0] z_out;
  logic       start = 1'b0, flush = 1'b0;
  logic [2:0] vec_st = 3'b000;
  logic [1:0] vec_x = 2'b00;
  logic       busy, res_valid, scan_valid;
  logic [1:0] res_z;
  logic [2:0] scan_st;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  scan_path_top u_scan_path_top (
    .clk(clk), .rst(rst), .ext_shift(ext_shift), .ext_cap(ext_cap),
    .ext_sdi(ext_sdi), .ext_x(ext_x), .sdo(sdo), .z_out(z_out),
    .start(start), .flush(flush), .vec_st(vec_st), .vec_x(vec_x),
    .busy(busy), .res_valid(res_valid), .res_z(res_z),
    .scan_valid(scan_valid), .scan_st(scan_st)
  );

  function automatic logic [2:0] exp_next(input logic [2:0] q, input logic [1:0] x);
    if (q == 3'b101) return (x == 2'b00) ? 3'b010 : (x == 2'b01) ? 3'b110 :
                            (x == 2'b11) ? 3'b011 : 3'b111;
    return {q[1] ^ x[1], q[0] ^ x[0], q[2] ^ x[1] ^ x[0]};
  endfunction

  function automatic logic [1:0] exp_z(input logic [2:0] q, input logic [1:0] x);
    if (q == 3'b101) return (x == 2'b00) ? 2'b10 : (x == 2'b01) ? 2'b11 :
                            (x == 2'b11) ? 2'b00 : 2'b01;
    return {q[2] ^ x[0], q[1] | x[1]};
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic ext_load(input logic [2:0] s);
    for (int i = 0; i < 3; i++) begin
      ext_shift = 1'b1; ext_sdi = s[i];
      @(negedge clk);
    end
    ext_shift = 1'b0; ext_sdi = 1'b0;
  endtask

  task automatic ext_read(output logic [2:0] s);
    for (int i = 0; i < 3; i++) begin
      s[i] = sdo;
      ext_shift = 1'b1;
      @(negedge clk);
    end
    ext_shift = 1'b0;
  endtask

  logic [2:0] prev_next;
  bit         have_prev;

  task automatic run_vec(input logic [2:0] s, input logic [1:0] x, input bit fl,
                         input bit inject);
    int cyc = 0;
    bit got_res = 0, got_scan = 0;
    logic [1:0] rz = 0;
    logic [2:0] ss = 0;
    start = 1'b1; flush = fl; vec_st = s; vec_x = x;
    @(negedge clk);
    start = 1'b0;
    while (1) begin
      if (res_valid) begin got_res = 1; rz = res_z; end
      if (scan_valid) begin got_scan = 1; ss = scan_st; end
      if (!busy || cyc > 20) break;
      cyc++;
      if (inject && cyc == 2) begin
        start = 1'b1; vec_st = ~s; vec_x = ~x; flush = ~fl;
        ext_shift = 1'b1; ext_cap = 1'b1; ext_sdi = 1'b1; ext_x = ~x;
      end else begin
        start = 1'b0; ext_shift = 1'b0; ext_cap = 1'b0; ext_sdi = 1'b0;
      end
      @(negedge clk);
    end
    start = 1'b0; ext_shift = 1'b0; ext_cap = 1'b0; ext_sdi = 1'b0; flush = 1'b0;
    check(cyc == (fl ? 3 : 5), fl ? "R9 flush busy length" : "R8 busy length",
          cyc, fl ? 3 : 5);
    check(got_scan == have_prev, "R9 scan_valid presence", got_scan, have_prev);
    if (have_prev && got_scan)
      check(ss == prev_next, "R9 scan_st", ss, prev_next);
    if (!fl) begin
      check(got_res, "R8 res_valid pulse", got_res, 1);
      check(rz == exp_z(s, x), inject ? "R10 res_z after injection" : "R8 res_z",
            rz, exp_z(s, x));
      prev_next = exp_next(s, x);
      have_prev = 1'b1;
    end else begin
      check(!got_res, "R9 flush gives no res_valid", got_res, 0);
      have_prev = 1'b0;
    end
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [2:0] rd;
    void'($urandom(32'd2024));
    have_prev = 1'b0;
    prev_next = 3'b000;
    @(negedge clk);
    // R1 during reset
    check(z_out == 0 && sdo == 0 && !busy && !res_valid && !scan_valid,
          "R1 reset outputs", {z_out, sdo, busy}, 0);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(z_out == 0 && sdo == 0 && !busy, "R1 first cycle", {z_out, sdo, busy}, 0);

    // R2 shift order both ways
    ext_load(3'b110);
    check(sdo == 1'b0, "R2 sdo shows Q3", sdo, 0);
    ext_read(rd);
    check(rd == 3'b110, "R2 load/unload order", rd, 3'b110);
    ext_load(3'b001);
    check(sdo == 1'b1, "R2 sdo shows Q3 after load", sdo, 1);
    ext_read(rd);
    check(rd == 3'b001, "R2 asymmetric pattern", rd, 3'b001);

    // R5 R6 row 101, Z and next state
    for (int xi = 0; xi < 4; xi++) begin
      ext_load(3'b101);
      ext_x = 2'(xi);
      @(negedge clk);
      check(z_out == exp_z(3'b101, 2'(xi)), "R6 R5 Z for state 101", z_out,
            exp_z(3'b101, 2'(xi)));
      ext_cap = 1'b1;
      @(negedge clk);
      ext_cap = 1'b0;
      ext_read(rd);
      check(rd == exp_next(3'b101, 2'(xi)), "R6 R3 next from 101", rd,
            exp_next(3'b101, 2'(xi)));
    end

    // R7 R3 R5 other rows, random
    for (int k = 0; k < 12; k++) begin
      logic [2:0] s;
      logic [1:0] x;
      s = 3'($urandom_range(0, 7));
      if (s == 3'b101) s = 3'b011;
      x = 2'($urandom_range(0, 3));
      ext_load(s);
      ext_x = x;
      @(negedge clk);
      check(z_out == exp_z(s, x), "R7 R5 Z other row", z_out, exp_z(s, x));
      @(negedge clk);
      ext_read(rd);
      check(rd == s, "R3 state holds without steps", rd, s);
      ext_load(s);
      ext_cap = 1'b1;
      @(negedge clk);
      ext_cap = 1'b0;
      ext_read(rd);
      check(rd == exp_next(s, x), "R7 R3 next other row", rd, exp_next(s, x));
    end

    // R4 shift beats capture
    ext_load(3'b101);
    ext_x = 2'b00;
    ext_shift = 1'b1; ext_cap = 1'b1; ext_sdi = 1'b1;
    @(negedge clk);
    ext_shift = 1'b0; ext_cap = 1'b0; ext_sdi = 1'b0;
    ext_read(rd);
    check(rd == 3'b110, "R4 shift priority", rd, 3'b110);
    ext_x = 2'b00;

    // R8 R9 sequencer with overlap
    for (int k = 0; k < 20; k++) begin
      run_vec(3'($urandom_range(0, 7)), 2'($urandom_range(0, 3)), 1'b0, 1'b0);
    end
    run_vec(3'b101, 2'b10, 1'b0, 1'b0);
    // R10 disturbance while busy
    run_vec(3'b011, 2'b01, 1'b0, 1'b1);
    run_vec(3'b110, 2'b11, 1'b0, 1'b0);
    run_vec(3'b000, 2'b00, 1'b1, 1'b0);
    ext_read(rd);
    check(rd == 3'b000, "R9 flush leaves zero state", rd, 0);
    run_vec(3'b111, 2'b10, 1'b0, 1'b0);
    run_vec(3'b000, 2'b00, 1'b1, 1'b0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule